// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Extended Lines

This block collects up to 31 interrupt lines and presents a 4-bit request level to each of `NCPU` processors. Lines 1 to 15 map one to one onto request levels 1 to 15. Lines 16 to 31 are extended lines. Every pending, enabled extended line is shown to a processor on one shared level, `EXT_LEVEL`. If `EXT_LEVEL` is 0, extended lines never raise a request.

A rising edge on an input line marks that line pending. Each processor has its own enable mask and its own force register. A processor's request is the highest-priority level among the lines that are pending or forced for it and enabled in its mask.

When a processor acknowledges a level, the line behind that level is retired:
- If the level is `EXT_LEVEL`, the line retired is the highest-numbered active extended line for that processor.
- Otherwise the line retired is the one with the same number as the level.

The processor's extended-acknowledge register records which extended line it took. Software reaches all registers through a single-cycle 32-bit write port and a combinational read port.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset the priority-group, pending, force and mask registers read 0, every extended-acknowledge register reads 0, and every request output is 0.
- R2: A rising edge on `irq_in[k]` (k from 1 to 31) sets pending bit k. A write to offset 0x04 loads the pending register from `bus_wdata` (bit 0 always reads 0).
- R3: Writing a 1 to bit k at offset 0x0C clears pending bit k. Offset 0x0C reads 0. A rising edge on the same line in the same cycle wins over the clear.
- R4: Line k can raise a request on processor c only when bit k of that processor's mask (offset 0x40 + 4c) is set. With a zero mask the processor's request is 0.
- R5: The request output (`irl_out[4c+3:4c]`) is the highest active level for processor c, registered one cycle after the state it is computed from.
  - A level whose bit is set in the priority-group register (offset 0x00, bits 15:1) beats every level whose bit is clear.
  - Within a group, the higher number wins.
  - The output is 0 when no level is active.
- R6: Any active extended line (16 to 31) makes level `EXT_LEVEL` active for that processor. The default `EXT_LEVEL` is 12.
- R7: When processor c acknowledges level `EXT_LEVEL`, bits 4:0 of its extended-acknowledge register (offset 0xC0 + 4c) latch the number of the highest active extended line, or 0 if none is active. Acknowledging any other level latches 0. The register never holds a value from 1 to 15.
- R8: An acknowledge retires its target line:
  - If processor c's force bit for that line is set, the force bit is cleared.
  - Otherwise the shared pending bit is cleared.
- R9: Each processor has its own force register at offset 0x80 + 4c, and its bits act like pending bits for that processor only. Offset 0x08 is a second address for the force register of processor 0.
- R10: Offset 0x10, offsets for processors at or beyond `NCPU`, and unused offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32 | Interrupt lines, bit 0 unused |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ack_valid | input | NCPU | Per-processor acknowledge strobe |
| ack_level | input | 4*NCPU | Level acknowledged by each processor |
| irl_out | output | 4*NCPU | Registered request level per processor |

## Verification
The assertions take for granted that bit 0 of `irq_in` carries no meaning and that a bus write lasts exactly one cycle. Under those assumptions, a clear written in the same cycle as an edge is resolved in favour of the edge. Each processor acknowledges at most once per cycle and only with a level in 0 to 15. The directed stimulus keeps inputs low across reset, so no edge is seen at release. It raises each line for exactly one cycle, drives writes and acknowledges as single-cycle strobes away from the clock edge, and only acknowledges levels the bench expects to be presented.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
    localparam int unsigned SRC_W  = 32;
    localparam int unsigned LVL_W  = 4;
    localparam int unsigned ID_W   = 5;
    localparam int unsigned BUS_AW = 8;

    localparam logic [1:0] BANK_GLOBAL = 2'd0;
    localparam logic [1:0] BANK_MASK   = 2'd1;
    localparam logic [1:0] BANK_FORCE  = 2'd2;
    localparam logic [1:0] BANK_EXTACK = 2'd3;

    localparam logic [3:0] SEL_GROUP  = 4'd0;
    localparam logic [3:0] SEL_PEND   = 4'd1;
    localparam logic [3:0] SEL_FORCE0 = 4'd2;
    localparam logic [3:0] SEL_CLEAR  = 4'd3;

    function automatic logic [LVL_W-1:0] highest_level(input logic [15:0] vec);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i < 16; i++) begin
            if (vec[i]) r = LVL_W'(i);
        end
        return r;
    endfunction

    function automatic logic [ID_W-1:0] highest_ext(input logic [15:0] vec);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = 0; i < 16; i++) begin
            if (vec[i]) r = ID_W'(16 + i);
        end
        return r;
    endfunction
endpackage

// File: rtl/mpic_edge_det.sv
module mpic_edge_det #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lines;
    end

    assign rise = lines & ~prev_q;
endmodule

// File: rtl/mpic_cpu_sel.sv
module mpic_cpu_sel
    import mpic_pkg::*;
#(
    parameter int unsigned EXT_LEVEL = 12
) (
    input  logic [SRC_W-1:0] active,
    input  logic [15:0]      group_hi,
    output logic [LVL_W-1:0] level,
    output logic [ID_W-1:0]  ext_id
);
    localparam logic [LVL_W-1:0] EXT_L = LVL_W'(EXT_LEVEL);
    localparam bool_ext = (EXT_LEVEL != 0);

    logic        ext_any;
    logic [15:0] lvl_vec;
    logic [15:0] hi_vec;

    assign ext_any = bool_ext && (|active[31:16]);

    always_comb begin
        lvl_vec = '0;
        for (int l = 1; l < 16; l++) begin
            lvl_vec[l] = active[l] || (ext_any && (EXT_L == LVL_W'(l)));
        end
    end

    assign hi_vec = lvl_vec & {group_hi[15:1], 1'b0};
    assign level  = (|hi_vec) ? highest_level(hi_vec) : highest_level(lvl_vec);
    assign ext_id = bool_ext ? highest_ext(active[31:16]) : '0;
endmodule

// File: rtl/mpic_ack_unit.sv
module mpic_ack_unit
    import mpic_pkg::*;
#(
    parameter int unsigned EXT_LEVEL = 12
) (
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    input  logic [ID_W-1:0]  ext_id,
    input  logic [SRC_W-1:0] force_bits,
    output logic [SRC_W-1:0] clr_pend,
    output logic [SRC_W-1:0] clr_force,
    output logic             id_load,
    output logic [ID_W-1:0]  id_next
);
    localparam logic [LVL_W-1:0] EXT_L = LVL_W'(EXT_LEVEL);

    logic             is_ext;
    logic [ID_W-1:0]  target;
    logic [SRC_W-1:0] onehot;
    logic             from_force;

    assign is_ext  = (EXT_LEVEL != 0) && (ack_level == EXT_L);
    assign target  = (is_ext && ext_id != '0) ? ext_id : {1'b0, ack_level};
    assign onehot  = (ack_valid && target != '0) ? (SRC_W'(1) << target) : '0;
    assign from_force = |(force_bits & onehot);

    assign clr_force = from_force ? onehot : '0;
    assign clr_pend  = from_force ? '0 : onehot;
    assign id_load   = ack_valid;
    assign id_next   = is_ext ? ext_id : '0;
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
    import mpic_pkg::*;
#(
    parameter int unsigned NCPU      = 2,
    parameter int unsigned EXT_LEVEL = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SRC_W-1:0]      irq_in,
    input  logic                  bus_we,
    input  logic [BUS_AW-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NCPU-1:0]       ack_valid,
    input  logic [NCPU*LVL_W-1:0] ack_level,
    output logic [NCPU*LVL_W-1:0] irl_out
);
    localparam logic [SRC_W-1:0] NO_BIT0 = ~SRC_W'(1);

    logic [SRC_W-1:0] rise_raw;
    logic [SRC_W-1:0] rise;
    logic [15:0]      group_q;
    logic [SRC_W-1:0] pend_q;
    logic [SRC_W-1:0] pend_nx;
    logic [SRC_W-1:0] clr_all;

    logic [NCPU*SRC_W-1:0] mask_flat;
    logic [NCPU*SRC_W-1:0] force_flat;
    logic [NCPU*SRC_W-1:0] clrp_flat;
    logic [NCPU*ID_W-1:0]  extack_flat;

    logic [1:0] bank;
    logic [3:0] sel;
    logic       we_group, we_pend, we_force0, we_clear;
    logic       unused_bits;

    assign bank = bus_addr[7:6];
    assign sel  = bus_addr[5:2];
    assign unused_bits = ^{bus_addr[1:0], rise_raw[0]};

    assign we_group  = bus_we && bank == BANK_GLOBAL && sel == SEL_GROUP;
    assign we_pend   = bus_we && bank == BANK_GLOBAL && sel == SEL_PEND;
    assign we_force0 = bus_we && bank == BANK_GLOBAL && sel == SEL_FORCE0;
    assign we_clear  = bus_we && bank == BANK_GLOBAL && sel == SEL_CLEAR;

    mpic_edge_det #(.WIDTH(SRC_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_in),
        .rise  (rise_raw)
    );
    assign rise = rise_raw & NO_BIT0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        group_q <= '0;
        else if (we_group) group_q <= {bus_wdata[15:1], 1'b0};
    end

    always_comb begin
        clr_all = we_clear ? bus_wdata : '0;
        for (int c = 0; c < NCPU; c++) begin
            clr_all = clr_all | clrp_flat[c*SRC_W +: SRC_W];
        end
        pend_nx = (((we_pend ? bus_wdata : pend_q) & ~clr_all) | rise) & NO_BIT0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nx;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [SRC_W-1:0] mask_q, force_q, act, clr_p, clr_f;
        logic [ID_W-1:0]  extack_q, ext_id, id_next;
        logic [LVL_W-1:0] lvl_nx, irl_q;
        logic             we_mask, we_force, id_load;

        assign we_mask  = bus_we && bank == BANK_MASK && sel == 4'(c);
        assign we_force = (bus_we && bank == BANK_FORCE && sel == 4'(c)) ||
                          (c == 0 && we_force0);
        assign act = (pend_q | force_q) & mask_q;

        mpic_cpu_sel #(.EXT_LEVEL(EXT_LEVEL)) u_sel (
            .active   (act),
            .group_hi (group_q),
            .level    (lvl_nx),
            .ext_id   (ext_id)
        );

        mpic_ack_unit #(.EXT_LEVEL(EXT_LEVEL)) u_ack (
            .ack_valid  (ack_valid[c]),
            .ack_level  (ack_level[c*LVL_W +: LVL_W]),
            .ext_id     (ext_id),
            .force_bits (force_q),
            .clr_pend   (clr_p),
            .clr_force  (clr_f),
            .id_load    (id_load),
            .id_next    (id_next)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_q   <= '0;
                force_q  <= '0;
                extack_q <= '0;
                irl_q    <= '0;
            end else begin
                if (we_mask) mask_q <= bus_wdata & NO_BIT0;
                force_q <= ((we_force ? bus_wdata : force_q) & ~clr_f) & NO_BIT0;
                if (id_load) extack_q <= id_next;
                irl_q <= lvl_nx;
            end
        end

        assign mask_flat[c*SRC_W +: SRC_W]   = mask_q;
        assign force_flat[c*SRC_W +: SRC_W]  = force_q;
        assign clrp_flat[c*SRC_W +: SRC_W]   = clr_p;
        assign extack_flat[c*ID_W +: ID_W]   = extack_q;
        assign irl_out[c*LVL_W +: LVL_W]     = irl_q;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bank)
            BANK_GLOBAL: begin
                if (sel == SEL_GROUP)       bus_rdata = {16'b0, group_q};
                else if (sel == SEL_PEND)   bus_rdata = pend_q;
                else if (sel == SEL_FORCE0) bus_rdata = force_flat[SRC_W-1:0];
            end
            BANK_MASK: begin
                if (32'(sel) < NCPU) bus_rdata = mask_flat[32'(sel)*SRC_W +: SRC_W];
            end
            BANK_FORCE: begin
                if (32'(sel) < NCPU) bus_rdata = force_flat[32'(sel)*SRC_W +: SRC_W];
            end
            BANK_EXTACK: begin
                if (32'(sel) < NCPU) bus_rdata = {27'b0, extack_flat[32'(sel)*ID_W +: ID_W]};
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mpic_checker.sv
module mpic_checker #(
    parameter int unsigned NCPU = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NCPU*4-1:0]   irl_out,
    input logic [NCPU*32-1:0]  mask_flat,
    input logic [NCPU*5-1:0]   extack_flat,
    input logic [31:0]         pend_q,
    input logic [31:0]         rise,
    input logic                bus_we,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_wdata
);
    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_flat[c*32 +: 32] == '0) |=> (irl_out[c*4 +: 4] == 4'd0)) else $error("mask"); // R4
        AST_EXTACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (extack_flat[c*5 +: 5] == 5'd0) || extack_flat[c*5 + 4]) else $error("extack"); // R7
    end

    AST_CLEAR_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[7:2] == 6'h03) |=> ((pend_q & $past(bus_wdata & ~rise)) == '0)) else $error("clear"); // R3
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend_q & $past(rise)) == $past(rise))) else $error("edge"); // R2
endmodule

bind mp_irq_ctrl mpic_checker #(.NCPU(NCPU)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irl_out     (irl_out),
    .mask_flat   (mask_flat),
    .extack_flat (extack_flat),
    .pend_q      (pend_q),
    .rise        (rise),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata)
);

// File: tb/mp_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module mp_irq_ctrl_tb_top;
    localparam int NCPU = 2;
    localparam int EXT  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [31:0]       irq_in = '0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NCPU-1:0]   ack_valid = '0;
    logic [NCPU*4-1:0] ack_level = '0;
    logic [NCPU*4-1:0] irl_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    mp_irq_ctrl #(.NCPU(NCPU), .EXT_LEVEL(EXT)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ack_valid(ack_valid), .ack_level(ack_level), .irl_out(irl_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] lines);
        @(negedge clk);
        irq_in = lines;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic ack(input int c, input int lvl);
        @(negedge clk);
        ack_valid[c] = 1'b1;
        ack_level[c*4 +: 4] = 4'(lvl);
        @(negedge clk);
        ack_valid[c] = 1'b0;
    endtask

    function automatic logic [31:0] irl(input int c);
        return {28'b0, irl_out[c*4 +: 4]};
    endfunction

    task automatic cleanup();
        wr(8'h0C, 32'hFFFF_FFFE);
        wr(8'h40, 0); wr(8'h44, 0); wr(8'h80, 0); wr(8'h84, 0); wr(8'h00, 0);
        tick(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h00, d); check("R1 group", d, 0);
        rd(8'h04, d); check("R1 pending", d, 0);
        rd(8'h40, d); check("R1 mask0", d, 0);
        rd(8'h84, d); check("R1 force1", d, 0);
        rd(8'hC0, d); check("R1 extack0", d, 0);
        check("R1 irl0", irl(0), 0);
        check("R1 irl1", irl(1), 0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        pulse(32'h20); tick(2);
        rd(8'h04, d); check("R2 edge sets pending", d, 32'h20);
        check("R4 masked irl0", irl(0), 0);
        wr(8'h40, 32'h20); tick(2);
        check("R4 enabled irl0", irl(0), 5);
        check("R4 other cpu masked", irl(1), 0);
        wr(8'h04, 32'h801); tick(2);
        rd(8'h04, d); check("R2 pending write", d, 32'h800);
        check("R4 irl0 after pending write", irl(0), 0);
        cleanup();
    endtask

    task automatic t_priority();
        logic [31:0] d;
        pulse(32'h208); wr(8'h40, 32'h208); tick(2);
        check("R5 higher number wins", irl(0), 9);
        wr(8'h00, 32'h8); tick(2);
        check("R5 high group wins", irl(0), 3);
        rd(8'h00, d); check("R5 group readback", d, 32'h8);
        wr(8'h0C, 32'h8); tick(2);
        check("R3 clear drops level", irl(0), 9);
        rd(8'h0C, d); check("R3 clear reads zero", d, 0);
        wr(8'h0C, 32'h200); tick(2);
        check("R5 none active", irl(0), 0);
        cleanup();
    endtask

    task automatic t_ext();
        logic [31:0] d;
        wr(8'h44, 32'h0810_0000); pulse(32'h0810_0000); tick(2);
        check("R6 ext routed to level", irl(1), EXT);
        check("R6 cpu0 masked", irl(0), 0);
        rd(8'hC4, d); check("R7 extack before ack", d, 0);
        ack(1, EXT); tick(2);
        rd(8'hC4, d); check("R7 extack highest", d, 27);
        rd(8'h04, d); check("R8 ext target cleared", d, 32'h0010_0000);
        check("R6 still on ext level", irl(1), EXT);
        ack(1, EXT); tick(2);
        rd(8'hC4, d); check("R7 extack next", d, 20);
        check("R8 all ext retired", irl(1), 0);
        ack(1, 3); tick(1);
        rd(8'hC4, d); check("R7 non-ext ack latches 0", d, 0);
        cleanup();
    endtask

    task automatic t_force();
        logic [31:0] d;
        wr(8'h84, 32'h80); wr(8'h44, 32'h80); wr(8'h40, 32'h80); tick(2);
        check("R9 force cpu1", irl(1), 7);
        check("R9 force private", irl(0), 0);
        ack(1, 7); tick(2);
        rd(8'h84, d); check("R8 ack clears force", d, 0);
        check("R8 irl1 after force ack", irl(1), 0);
        wr(8'h08, 32'h10); tick(1);
        rd(8'h80, d); check("R9 legacy alias", d, 32'h10);
        cleanup();
    endtask

    task automatic t_two_cpu();
        logic [31:0] d;
        pulse(32'h440); wr(8'h40, 32'h440); wr(8'h44, 32'h440); tick(2);
        check("R5 cpu0 both", irl(0), 10);
        check("R5 cpu1 both", irl(1), 10);
        ack(0, 10); tick(2);
        check("R8 cpu0 after ack", irl(0), 6);
        check("R8 cpu1 sees shared clear", irl(1), 6);
        ack(1, 6); tick(2);
        check("R8 cpu0 final", irl(0), 0);
        rd(8'h04, d); check("R8 pending empty", d, 0);
        cleanup();
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h10, d); check("R10 status zero", d, 0);
        rd(8'h4C, d); check("R10 absent cpu", d, 0);
        rd(8'h38, d); check("R10 unused offset", d, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_mask();
        t_priority();
        t_ext();
        t_force();
        t_two_cpu();
        t_unmapped();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule